// File: doc/BRIEF.md
# Segment Protection and Translation Unit

This block turns a segment selector and an offset into a linear address and decides whether the access may proceed. It keeps two small descriptor tables, one shared by all tasks (global) and one for the current task (local). Software or a loader fills the tables through a single write port, one descriptor per cycle. A descriptor holds a base address, a limit, a descriptor privilege level, a present bit, a code/data bit and one permission bit. For code segments that bit means "readable"; for data segments it means "writable".

Each request carries a selector, an offset, an access kind and the current privilege level. One cycle later the block returns a response. The response is either a grant with the linear address (base plus offset), or a fault with a reason code and a zero address. The checks run in a fixed priority order, so one cause is reported even when several apply.

Top module: `seg_xlate_unit`

## Requirements
- R1: Selector layout: bits [1:0] hold the requested privilege level and bit 2 picks the table (0 global, 1 local). Bits [IDX_W+2:3] hold the descriptor index, so the same index in the two tables yields different descriptors.
- R2: A request presented with `req_valid` high gives `rsp_valid` high for exactly the next cycle. A granted response carries `rsp_lin_addr` = base + offset, taken modulo 2^ADDR_W. A faulted response carries address 0.
- R3: If the index is not below the table depth (8 global, 5 local by default), or the selected descriptor has its present bit clear, the fault code is 1 (not present).
- R4: An offset greater than the descriptor limit gives fault code 2. An offset equal to the limit is allowed.
- R5: The effective level is the larger of the current level and the requested level. If it is numerically greater than the descriptor level, the fault code is 3 (privilege).
- R6: Access encoding is 0 fetch, 1 read, 2 write. A code segment always allows fetch. It allows read only when its permission bit is set, and never allows write. Any other case gives fault code 4.
- R7: A data segment always allows read. It allows write only when its permission bit is set, and never allows fetch. Any other case gives fault code 4.
- R8: When several faults apply, the lowest nonzero code is reported (1 before 2 before 3 before 4). `rsp_grant` is high exactly when the code is 0.
- R9: After reset, every descriptor is absent, and `rsp_valid`, `rsp_grant`, `rsp_fault` and `rsp_lin_addr` are all 0.
- R10: A table write takes effect for requests in later cycles. A request in the same cycle as a write to its own entry sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Descriptor write enable |
| tbl_local | input | 1 | Write target: 0 global, 1 local |
| tbl_idx | input | IDX_W | Entry written |
| tbl_base | input | ADDR_W | Segment base |
| tbl_limit | input | ADDR_W | Largest valid offset |
| tbl_dpl | input | 2 | Descriptor privilege level |
| tbl_present | input | 1 | Present bit |
| tbl_code | input | 1 | 1 code segment, 0 data segment |
| tbl_rw | input | 1 | Readable (code) or writable (data) |
| req_valid | input | 1 | Request strobe |
| req_sel | input | IDX_W+3 | Selector |
| req_offset | input | ADDR_W | Offset within segment |
| req_acc | input | 2 | Access kind |
| req_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 3 | Fault reason |
| rsp_lin_addr | output | ADDR_W | Linear address |

## Verification
The assertions assume the access kind is never the unused encoding 3; the bench drives only fetch, read and write. They also assume the write port and the request port are both sampled on the same edge. The bench keeps table writes and requests aligned to the falling edge, and overlaps them only in the one scenario that targets same-cycle ordering. Privilege levels are two-bit values, so every level the bench drives is legal.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_LIMIT  = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_TYPE   = 3'd4
  } flt_e;

  // less privileged of two levels (numerically larger)
  function automatic logic [1:0] eff_priv(input logic [1:0] cpl, input logic [1:0] rpl);
    return (cpl > rpl) ? cpl : rpl;
  endfunction

  // whether the segment kind permits the access kind
  function automatic logic type_allows(input logic [1:0] acc, input logic is_code,
                                       input logic rw_ok);
    logic ok;
    case (acc)
      ACC_FETCH: ok = is_code;
      ACC_READ:  ok = is_code ? rw_ok : 1'b1;
      ACC_WRITE: ok = !is_code && rw_ok;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [BASE_W-1:0] wr_limit,
  input  logic [1:0]        wr_dpl,
  input  logic              wr_present,
  input  logic              wr_code,
  input  logic              wr_rw,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [BASE_W-1:0] rd_base,
  output logic [BASE_W-1:0] rd_limit,
  output logic [1:0]        rd_dpl,
  output logic              rd_code,
  output logic              rd_rw
);

  localparam int SPAN = 1 << IDX_W;

  logic [BASE_W-1:0] base_q    [DEPTH];
  logic [BASE_W-1:0] limit_q   [DEPTH];
  logic [1:0]        dpl_q     [DEPTH];
  logic              present_q [DEPTH];
  logic              code_q    [DEPTH];
  logic              rw_q      [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        base_q[i]    <= '0;
        limit_q[i]   <= '0;
        dpl_q[i]     <= '0;
        present_q[i] <= 1'b0;
        code_q[i]    <= 1'b0;
        rw_q[i]      <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        base_q[i]    <= wr_base;
        limit_q[i]   <= wr_limit;
        dpl_q[i]     <= wr_dpl;
        present_q[i] <= wr_present;
        code_q[i]    <= wr_code;
        rw_q[i]      <= wr_rw;
      end
    end
  end

  logic in_range;
  generate
    if (DEPTH >= SPAN) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (rd_idx < IDX_W'(DEPTH));
    end
  endgenerate

  logic present_sel;
  always_comb begin
    rd_base     = '0;
    rd_limit    = '0;
    rd_dpl      = '0;
    rd_code     = 1'b0;
    rd_rw       = 1'b0;
    present_sel = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_base     = base_q[i];
        rd_limit    = limit_q[i];
        rd_dpl      = dpl_q[i];
        rd_code     = code_q[i];
        rd_rw       = rw_q[i];
        present_sel = present_q[i];
      end
    end
  end

  assign rd_hit = in_range && present_sel;

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check #(
  parameter int OFS_W = 32
) (
  input  logic             hit,
  input  logic [OFS_W-1:0] offset,
  input  logic [OFS_W-1:0] limit,
  input  logic [1:0]       cpl,
  input  logic [1:0]       rpl,
  input  logic [1:0]       dpl,
  input  logic [1:0]       acc,
  input  logic             is_code,
  input  logic             rw_ok,
  output logic [1:0]       eff,
  output logic             over_limit,
  output logic             priv_viol,
  output logic             type_viol,
  output logic [2:0]       fault,
  output logic             ok
);
  import seg_pkg::*;

  assign eff        = eff_priv(cpl, rpl);
  assign over_limit = offset > limit;
  assign priv_viol  = eff > dpl;
  assign type_viol  = !type_allows(acc, is_code, rw_ok);

  always_comb begin
    if (!hit)            fault = FLT_ABSENT;
    else if (over_limit) fault = FLT_LIMIT;
    else if (priv_viol)  fault = FLT_PRIV;
    else if (type_viol)  fault = FLT_TYPE;
    else                 fault = FLT_NONE;
  end

  assign ok = hit && !over_limit && !priv_viol && !type_viol;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int GDT_N  = 8,
  parameter int LDT_N  = 5,
  localparam int SEL_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic              tbl_local,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  input  logic [1:0]        tbl_dpl,
  input  logic              tbl_present,
  input  logic              tbl_code,
  input  logic              tbl_rw,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [2:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_lin_addr
);

  // selector fields
  logic [1:0]       sel_rpl;
  logic             sel_local;
  logic [IDX_W-1:0] sel_idx;
  assign sel_rpl   = req_sel[1:0];
  assign sel_local = req_sel[2];
  assign sel_idx   = req_sel[SEL_W-1:3];

  // table outputs
  logic              g_hit, l_hit, g_code, l_code, g_rw, l_rw;
  logic [ADDR_W-1:0] g_base, l_base, g_limit, l_limit;
  logic [1:0]        g_dpl, l_dpl;

  seg_desc_table #(.DEPTH(GDT_N), .IDX_W(IDX_W), .BASE_W(ADDR_W)) u_gtab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we && !tbl_local), .wr_idx(tbl_idx), .wr_base(tbl_base),
    .wr_limit(tbl_limit), .wr_dpl(tbl_dpl), .wr_present(tbl_present),
    .wr_code(tbl_code), .wr_rw(tbl_rw),
    .rd_idx(sel_idx), .rd_hit(g_hit), .rd_base(g_base), .rd_limit(g_limit),
    .rd_dpl(g_dpl), .rd_code(g_code), .rd_rw(g_rw)
  );

  seg_desc_table #(.DEPTH(LDT_N), .IDX_W(IDX_W), .BASE_W(ADDR_W)) u_ltab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we && tbl_local), .wr_idx(tbl_idx), .wr_base(tbl_base),
    .wr_limit(tbl_limit), .wr_dpl(tbl_dpl), .wr_present(tbl_present),
    .wr_code(tbl_code), .wr_rw(tbl_rw),
    .rd_idx(sel_idx), .rd_hit(l_hit), .rd_base(l_base), .rd_limit(l_limit),
    .rd_dpl(l_dpl), .rd_code(l_code), .rd_rw(l_rw)
  );

  // selected descriptor, named for the checker
  logic              w_hit, w_code, w_rw;
  logic [ADDR_W-1:0] w_base, w_limit;
  logic [1:0]        w_dpl;
  assign w_hit   = sel_local ? l_hit   : g_hit;
  assign w_base  = sel_local ? l_base  : g_base;
  assign w_limit = sel_local ? l_limit : g_limit;
  assign w_dpl   = sel_local ? l_dpl   : g_dpl;
  assign w_code  = sel_local ? l_code  : g_code;
  assign w_rw    = sel_local ? l_rw    : g_rw;

  logic [1:0] w_eff;
  logic       w_over, w_priv, w_type, w_ok;
  logic [2:0] w_fault;

  seg_rights_check #(.OFS_W(ADDR_W)) u_rights (
    .hit(w_hit), .offset(req_offset), .limit(w_limit), .cpl(req_cpl),
    .rpl(sel_rpl), .dpl(w_dpl), .acc(req_acc), .is_code(w_code), .rw_ok(w_rw),
    .eff(w_eff), .over_limit(w_over), .priv_viol(w_priv), .type_viol(w_type),
    .fault(w_fault), .ok(w_ok)
  );

  logic [ADDR_W-1:0] w_lin;
  assign w_lin = w_base + req_offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_grant    <= 1'b0;
      rsp_fault    <= '0;
      rsp_lin_addr <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_grant    <= req_valid && w_ok;
      rsp_fault    <= req_valid ? w_fault : 3'd0;
      rsp_lin_addr <= (req_valid && w_ok) ? w_lin : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_acc,
  input logic [ADDR_W-1:0] req_offset,
  input logic              w_hit,
  input logic              w_code,
  input logic [ADDR_W-1:0] w_limit,
  input logic [1:0]        w_dpl,
  input logic [1:0]        w_eff,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [2:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_lin_addr
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R2
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> rsp_lin_addr == '0);  // R2
  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !w_hit) |=> (!rsp_grant && rsp_fault == 3'd1));  // R3
  AST_LIMIT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && w_hit && req_offset > w_limit) |=> !rsp_grant);  // R4
  AST_PRIV_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && w_hit && w_eff > w_dpl) |=> !rsp_grant);  // R5
  AST_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && w_hit && w_code && req_acc == 2'd2) |=> !rsp_grant);  // R6
  AST_DATA_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && w_hit && !w_code && req_acc == 2'd0) |=> !rsp_grant);  // R7
  AST_GRANT_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_fault == 3'd0)));  // R8
  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault <= 3'd4);  // R8
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_grant && rsp_fault == 3'd0));  // R9

endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
  .req_offset(req_offset), .w_hit(w_hit), .w_code(w_code), .w_limit(w_limit),
  .w_dpl(w_dpl), .w_eff(w_eff), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
  .rsp_fault(rsp_fault), .rsp_lin_addr(rsp_lin_addr)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

  localparam int AW = 32;
  localparam int IW = 3;
  localparam int GN = 8;
  localparam int LN = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_we = 1'b0, tbl_local = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [AW-1:0] tbl_base = '0, tbl_limit = '0;
  logic [1:0]    tbl_dpl = '0;
  logic          tbl_present = 1'b0, tbl_code = 1'b0, tbl_rw = 1'b0;
  logic          req_valid = 1'b0;
  logic [IW+2:0] req_sel = '0;
  logic [AW-1:0] req_offset = '0;
  logic [1:0]    req_acc = '0, req_cpl = '0;
  logic          rsp_valid, rsp_grant;
  logic [2:0]    rsp_fault;
  logic [AW-1:0] rsp_lin_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  seg_xlate_unit #(.ADDR_W(AW), .IDX_W(IW), .GDT_N(GN), .LDT_N(LN)) u0 (.*);

  // bench-side table image
  logic [AW-1:0] m_base  [2][8];
  logic [AW-1:0] m_limit [2][8];
  logic [1:0]    m_dpl   [2][8];
  logic          m_pres  [2][8];
  logic          m_code  [2][8];
  logic          m_rw    [2][8];

  function automatic logic [2:0] exp_fault(input int t, input int idx, input logic [AW-1:0] ofs,
                                           input logic [1:0] acc, input logic [1:0] cpl,
                                           input logic [1:0] rpl);
    logic [1:0] lvl;
    if (idx >= ((t == 1) ? LN : GN) || !m_pres[t][idx]) return 3'd1;
    if (ofs > m_limit[t][idx]) return 3'd2;
    lvl = (rpl > cpl) ? rpl : cpl;
    if (lvl > m_dpl[t][idx]) return 3'd3;
    if (m_code[t][idx]) begin
      if (acc == 2'd2 || (acc == 2'd1 && !m_rw[t][idx])) return 3'd4;
    end else begin
      if (acc == 2'd0 || (acc == 2'd2 && !m_rw[t][idx])) return 3'd4;
    end
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int t, input int idx, input logic [AW-1:0] b,
                          input logic [AW-1:0] lim, input logic [1:0] d,
                          input logic p, input logic c, input logic rw);
    @(negedge clk);
    tbl_we = 1'b1; tbl_local = (t == 1); tbl_idx = IW'(idx);
    tbl_base = b; tbl_limit = lim; tbl_dpl = d;
    tbl_present = p; tbl_code = c; tbl_rw = rw;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[t][idx] = b; m_limit[t][idx] = lim; m_dpl[t][idx] = d;
    m_pres[t][idx] = p; m_code[t][idx] = c; m_rw[t][idx] = rw;
  endtask

  // issue one request and compare the response against the bench model
  task automatic access(input string tag, input int t, input int idx, input logic [1:0] rpl,
                        input logic [AW-1:0] ofs, input logic [1:0] acc, input logic [1:0] cpl);
    logic [2:0]    ef;
    logic [AW-1:0] ea;
    ef = exp_fault(t, idx, ofs, acc, cpl, rpl);
    ea = (ef == 3'd0) ? m_base[t][idx] + ofs : '0;
    @(negedge clk);
    req_valid = 1'b1; req_sel = {IW'(idx), (t == 1), rpl};
    req_offset = ofs; req_acc = acc; req_cpl = cpl;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, AW'(rsp_valid), 1);
    chk({tag, " fault"}, AW'(rsp_fault), AW'(ef));
    chk({tag, " grant"}, AW'(rsp_grant), AW'(ef == 3'd0));
    chk({tag, " addr"}, rsp_lin_addr, ea);
  endtask

  task automatic t_reset;
    chk("R9 valid", AW'(rsp_valid), 0);
    chk("R9 grant", AW'(rsp_grant), 0);
    chk("R9 fault", AW'(rsp_fault), 0);
    chk("R9 addr", rsp_lin_addr, 0);
    access("R9 empty global", 0, 2, 2'd0, 32'h0, 2'd1, 2'd0);
    access("R9 empty local", 1, 0, 2'd0, 32'h0, 2'd1, 2'd0);
  endtask

  task automatic t_tables;
    put_desc(0, 1, 32'h0000_1000, 32'hFF, 2'd3, 1, 0, 1);
    put_desc(1, 1, 32'h0002_0000, 32'hFF, 2'd3, 1, 0, 1);
    access("R1 global idx1", 0, 1, 2'd0, 32'h10, 2'd1, 2'd3);
    access("R1 local idx1", 1, 1, 2'd0, 32'h10, 2'd1, 2'd3);
    @(negedge clk);
    chk("R2 single-cycle valid", AW'(rsp_valid), 0);
  endtask

  task automatic t_wrap;
    put_desc(0, 7, 32'hFFFF_FFF0, 32'hFFFF, 2'd3, 1, 0, 1);
    access("R2 wrap", 0, 7, 2'd0, 32'h20, 2'd1, 2'd0);
  endtask

  task automatic t_absent;
    put_desc(0, 3, 32'h4000, 32'hFF, 2'd3, 0, 0, 1);
    access("R3 present clear", 0, 3, 2'd0, 32'h1, 2'd1, 2'd0);
    access("R3 local idx beyond depth", 1, 6, 2'd0, 32'h1, 2'd1, 2'd0);
  endtask

  task automatic t_limit;
    access("R4 at limit", 0, 1, 2'd0, 32'hFF, 2'd1, 2'd0);
    access("R4 past limit", 0, 1, 2'd0, 32'h100, 2'd1, 2'd0);
  endtask

  task automatic t_priv;
    put_desc(0, 2, 32'h8000, 32'hFFF, 2'd0, 1, 0, 1);
    put_desc(0, 4, 32'h9000, 32'hFFF, 2'd2, 1, 0, 1);
    access("R5 ring0 ok", 0, 2, 2'd0, 32'h4, 2'd1, 2'd0);
    access("R5 rpl weaker", 0, 2, 2'd3, 32'h4, 2'd1, 2'd0);
    access("R5 cpl weaker", 0, 2, 2'd0, 32'h4, 2'd1, 2'd2);
    access("R5 equal level", 0, 4, 2'd2, 32'h4, 2'd2, 2'd1);
    access("R5 level3 vs 2", 0, 4, 2'd1, 32'h4, 2'd1, 2'd3);
  endtask

  task automatic t_code;
    put_desc(0, 5, 32'hA000, 32'hFFF, 2'd3, 1, 1, 0);
    put_desc(1, 3, 32'hB000, 32'hFFF, 2'd3, 1, 1, 1);
    access("R6 fetch", 0, 5, 2'd0, 32'h8, 2'd0, 2'd3);
    access("R6 read unreadable", 0, 5, 2'd0, 32'h8, 2'd1, 2'd3);
    access("R6 write", 0, 5, 2'd0, 32'h8, 2'd2, 2'd3);
    access("R6 read readable", 1, 3, 2'd0, 32'h8, 2'd1, 2'd3);
    access("R6 write readable", 1, 3, 2'd0, 32'h8, 2'd2, 2'd3);
  endtask

  task automatic t_data;
    put_desc(0, 6, 32'hC000, 32'hFFF, 2'd3, 1, 0, 0);
    access("R7 read ro", 0, 6, 2'd0, 32'h8, 2'd1, 2'd3);
    access("R7 write ro", 0, 6, 2'd0, 32'h8, 2'd2, 2'd3);
    access("R7 fetch data", 0, 6, 2'd0, 32'h8, 2'd0, 2'd3);
    access("R7 write rw", 0, 1, 2'd0, 32'h8, 2'd2, 2'd3);
  endtask

  task automatic t_priority;
    // ring-0 code segment, unreadable
    put_desc(1, 4, 32'hD000, 32'h10, 2'd0, 1, 1, 0);
    access("R8 limit over priv/type", 1, 4, 2'd3, 32'h20, 2'd2, 2'd3);
    access("R8 priv over type", 1, 4, 2'd3, 32'h4, 2'd2, 2'd3);
    access("R8 absent over all", 0, 3, 2'd3, 32'hFFFF, 2'd2, 2'd3);
  endtask

  task automatic t_same_cycle;
    logic [AW-1:0] old_b;
    old_b = m_base[0][1];
    @(negedge clk);
    tbl_we = 1'b1; tbl_local = 1'b0; tbl_idx = 3'd1;
    tbl_base = 32'h0005_0000; tbl_limit = 32'hFF; tbl_dpl = 2'd3;
    tbl_present = 1'b1; tbl_code = 1'b0; tbl_rw = 1'b1;
    req_valid = 1'b1; req_sel = {3'd1, 1'b0, 2'd0};
    req_offset = 32'h10; req_acc = 2'd1; req_cpl = 2'd0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle old base", rsp_lin_addr, old_b + 32'h10);
    m_base[0][1] = 32'h0005_0000;
    access("R10 next cycle new base", 0, 1, 2'd0, 32'h10, 2'd1, 2'd0);
  endtask

  logic done = 1'b0;

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        m_base[t][i] = '0; m_limit[t][i] = '0; m_dpl[t][i] = '0;
        m_pres[t][i] = 1'b0; m_code[t][i] = 1'b0; m_rw[t][i] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tables();
    t_wrap();
    t_absent();
    t_limit();
    t_priv();
    t_code();
    t_data();
    t_priority();
    t_same_cycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule